// File: doc/BRIEF.md
# Preloadable Base Timer with Sticky Interrupt

This block is an 8-bit up-counter that advances once per microsecond. It produces the microsecond tick itself by dividing the 4 MHz system clock by a parameterised factor, four by default. Software drives it through a small write-only register port that holds three registers:

- A preload register sets the count at any moment.
- A control register starts and stops counting. Its enable bit is active when written as zero.
- A clear register drops the pending interrupt.

When the count passes from its maximum value back to zero, a sticky flag is set. The flag drives a level interrupt request to the processor. Software cannot read the flag. It stays high until software writes a one to the clear register. Preloading value `v` gives an interrupt period of `256 - v` ticks, so the interval can be set anywhere from 1 to 256 microseconds.

Register decode:
- Preload register at offset `0xC0`: the full data byte becomes the count.
- Control register at `0xC1`: only bit 0 is used. 0 means run, 1 means stop.
- Clear register at `0xC2`: only bit 0 is used. A 1 clears the flag.

Writes to any other address do nothing.

Top module: `pbt_timer`

## Requirements
- R1: A synchronous reset sets the count to 0x00 and the interrupt to 0. It also leaves the timer stopped, so the count stays at 0x00 until counting is enabled.
- R2: A write to 0xC1 with bit 0 equal to 0 starts counting, whatever the upper data bits hold. A write with bit 0 equal to 1 freezes the count at its present value.
- R3: While running, the count rises by exactly one every DIV clock cycles. The first increment lands DIV cycles after the enabling write.
- R4: A write to 0xC0 loads the data byte into the count on the next cycle, whether the timer is running or stopped. When running, the next increment comes DIV cycles after the load.
- R5: When a tick arrives with the count at 0xFF, the count becomes 0x00 and `irq` goes high in the same cycle. After preload `v` and enable, this happens exactly DIV*(256-v) cycles after the enabling write.
- R6: Once high, `irq` stays high while counting continues. It also stays high through a write to 0xC2 with bit 0 equal to 0 and through writes to other registers.
- R7: A write to 0xC2 with bit 0 equal to 1 drops `irq` on the next cycle, unless an overflow occurs in that same cycle.
- R8: When a clearing write and an overflow land on the same cycle, `irq` is high afterwards.
- R9: Writes to addresses other than 0xC0, 0xC1 and 0xC2 change neither the count, nor `irq`, nor the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| count | output | 8 | Present counter value |
| irq | output | 1 | Level interrupt request (sticky flag) |

## Verification
Suppose the prescaler phase is wrong. Then every increment moves on `count`, and the error shows within DIV cycles of an enable or a preload. A wrong run/stop state shows as a count that moves or freezes within one tick period. A wrong flag, or a wrong priority between clear and set, shows on `irq` in the cycle right after the overflow or the clearing write. The sweep over preload values pins the overflow cycle of each sampled interval, so an off-by-one in the wrap decode shows as `irq` rising one tick early or late.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_PRELOAD = 8'hC0;
    localparam logic [ADDR_W-1:0] ADDR_CONTROL = 8'hC1;
    localparam logic [ADDR_W-1:0] ADDR_CLEAR   = 8'hC2;

    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] load_val;
        logic             clr;
    } wr_cmd_t;

    function automatic logic at_top(input logic [CNT_W-1:0] v);
        return v == {CNT_W{1'b1}};
    endfunction
endpackage

// File: rtl/pbt_regif.sv
module pbt_regif
    import pbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd,
    output logic              enabled
);
    logic stop_q;

    always_comb begin
        cmd.load     = wr_en && (wr_addr == ADDR_PRELOAD);
        cmd.load_val = wr_data[CNT_W-1:0];
        cmd.clr      = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b1;
        end else if (wr_en && (wr_addr == ADDR_CONTROL)) begin
            stop_q <= wr_data[0];
        end
    end

    assign enabled = !stop_q;
endmodule

// File: rtl/pbt_prescaler.sv
module pbt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enabled,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_direct
            assign tick = enabled;
        end else begin : g_div
            logic [PW-1:0] phase_q;
            logic          last;

            assign last = (phase_q == PW'(DIV - 1));
            assign tick = enabled && last;

            always_ff @(posedge clk) begin
                if (rst || !enabled || restart) begin
                    phase_q <= '0;
                end else if (last) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + PW'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pbt_counter.sv
module pbt_counter
    import pbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wr_cmd_t          cmd,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    logic [CNT_W-1:0] cnt_q;

    assign overflow = tick && !cmd.load && at_top(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cmd.load) begin
            cnt_q <= cmd.load_val;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/pbt_irqflag.sv
module pbt_irqflag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_ev) begin
            flag_q <= 1'b1;
        end else if (clr_ev) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/pbt_timer.sv
module pbt_timer
    import pbt_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    wr_cmd_t cmd;
    logic    enabled;
    logic    tick;
    logic    overflow;

    pbt_regif u_regif (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd),
        .enabled (enabled)
    );

    pbt_prescaler #(.DIV(DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .enabled (enabled),
        .restart (cmd.load),
        .tick    (tick)
    );

    pbt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd      (cmd),
        .count    (count),
        .overflow (overflow)
    );

    pbt_irqflag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (overflow),
        .clr_ev (cmd.clr),
        .flag   (irq)
    );
endmodule

// File: rtl/pbt_timer_chk.sv
module pbt_timer_chk
    import pbt_pkg::*;
#(
    parameter int DIV = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  count,
    input logic              irq,
    input logic              tick,
    input logic              enabled
);
    logic wr_pre, wr_clr;
    assign wr_pre = wr_en && (wr_addr == ADDR_PRELOAD);
    assign wr_clr = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !irq && !enabled));

    p_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (!enabled && !wr_pre) |=> $stable(count));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_pre) |=> count == $past(count) + CNT_W'(1));

    generate
        if (DIV > 1) begin : g_gap
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        wr_pre |=> count == $past(wr_data[CNT_W-1:0]));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_pre && count == {CNT_W{1'b1}}) |=> (irq && count == '0));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_clr) |=> irq);

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !(tick && !wr_pre && count == {CNT_W{1'b1}})) |=> !irq);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && tick && !wr_pre && count == {CNT_W{1'b1}}) |=> irq);
endmodule

bind pbt_timer pbt_timer_chk #(.DIV(DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count   (count),
    .irq     (irq),
    .tick    (tick),
    .enabled (enabled)
);

// File: tb/pbt_timer_test.sv
`timescale 1ns/1ps
module pbt_timer_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] count;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pbt_timer #(.DIV(DIV)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write takes the next posedge; returns at the following negedge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state and stopped timer
        check("R1 count", count, 0);
        check("R1 irq", irq, 0);
        cycles(10);
        check("R1 stopped", count, 0);

        // R2/R3: enable with upper bits set; one step per DIV cycles
        wr(8'hC1, 8'hFE);
        for (int n = 1; n <= 12; n++) begin
            cycles(1);
            check("R3 step", count, n / DIV);
        end
        wr(8'hC1, 8'h01);
        check("R2 freeze at write", count, 3);
        cycles(20);
        check("R2 frozen", count, 3);

        // R4: preload while running restarts the tick phase
        wr(8'hC1, 8'h00);
        cycles(6);
        check("R4 pre-load count", count, 4);
        wr(8'hC0, 8'h50);
        check("R4 loaded", count, 8'h50);
        cycles(DIV - 1);
        check("R4 no early step", count, 8'h50);
        cycles(1);
        check("R4 first step", count, 8'h51);

        // R4: preload while stopped
        wr(8'hC1, 8'h01);
        wr(8'hC0, 8'h33);
        cycles(8);
        check("R4 stopped load", count, 8'h33);

        // R9: foreign addresses ignored
        wr(8'hC3, 8'h00);
        wr(8'hC5, 8'hFF);
        wr(8'h41, 8'h00);
        cycles(8);
        check("R9 count", count, 8'h33);
        check("R9 irq", irq, 0);

        // R5: sweep of preload values
        for (int v = 0; v < 256; v += 5) begin
            wr(8'hC1, 8'h01);
            wr(8'hC2, 8'h01);
            wr(8'hC0, v[7:0]);
            wr(8'hC1, 8'h00);
            cycles(DIV * (256 - v) - 1);
            check("R5 before wrap irq", irq, 0);
            check("R5 before wrap count", count, 8'hFF);
            cycles(1);
            check("R5 wrap irq", irq, 1);
            check("R5 wrap count", count, 0);
        end

        // R6: sticky across counting and non-clearing writes
        wr(8'hC2, 8'hFE);
        check("R6 bit0 zero clear", irq, 1);
        wr(8'hC0, 8'h10);
        wr(8'hC7, 8'h01);
        cycles(3 * DIV);
        check("R6 sticky", irq, 1);
        check("R6 counting on", count, 8'h13);

        // R7: clear
        wr(8'hC2, 8'h01);
        check("R7 cleared", irq, 0);

        // R8: clear and overflow on the same edge
        wr(8'hC1, 8'h01);
        wr(8'hC0, 8'hFF);
        wr(8'hC1, 8'h00);
        cycles(DIV - 1);
        check("R8 pre irq", irq, 0);
        wr(8'hC2, 8'h01);
        check("R8 set wins", irq, 1);
        check("R8 wrapped", count, 0);
        wr(8'hC2, 8'h03);
        check("R7 second clear", irq, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule